// File: doc/BRIEF.md
# Sequential Accumulator Multiply/Divide Unit

This block performs unsigned multiplication and division on fixed, implied accumulator operands, one result bit per clock. A byte multiply takes the low byte of the accumulator (AL) times the low byte of the source and returns a 16-bit product in AX. A word multiply takes AX times the 16-bit source and returns a 32-bit product, with the upper half in DX and the lower half in AX.

A byte divide splits AX by the low byte of the source and returns the quotient in AL and the remainder in AH. A word divide splits the 32-bit pair DX:AX by the 16-bit source and returns the quotient in AX and the remainder in DX.

The surrounding core raises a start pulse with the operation, width, source and the current AX and DX values. All of these are captured in that cycle. Some clocks later the unit returns the updated AX and DX together with the carry, overflow and divide-error indications, and marks that moment with a one-cycle done pulse. A divide whose quotient cannot fit, including one by zero, is reported as an error and leaves both registers as they were.

Top module: `mdu_accum`

## Requirements
- R1: Byte multiply (op_div_i=0, word_i=0): ax_o = ax_i[7:0] * src_i[7:0] as 16 bits, dx_o = dx_i. src_i[15:8] and ax_i[15:8] have no effect. Example: FDh * 05h gives ax_o = 04F1h.
- R2: Word multiply (op_div_i=0, word_i=1): {dx_o, ax_o} = ax_i * src_i as 32 bits.
- R3: After a multiply, cf_o and of_o are both 1 when the upper product half is nonzero. That half is ax_o[15:8] for byte and dx_o for word. Otherwise both are 0, and div_err_o is 0.
- R4: Byte divide (op_div_i=1, word_i=0) with no error: ax_o[7:0] = ax_i / src_i[7:0], ax_o[15:8] = ax_i % src_i[7:0], dx_o = dx_i.
- R5: Word divide (op_div_i=1, word_i=1) with no error: ax_o = {dx_i, ax_i} / src_i and dx_o = {dx_i, ax_i} % src_i.
- R6: A divide is in error when the upper dividend half is not below the divisor. That half is ax_i[15:8] for byte and dx_i for word, so a zero divisor is always in error. On error div_err_o = 1, ax_o = ax_i and dx_o = dx_i. A divide without error gives div_err_o = 0.
- R7: A divide leaves cf_o and of_o at their previous values.
- R8: When start_i is sampled high by an idle unit, done_o rises N+1 clock edges later, where N is 8 for byte and 16 for word. done_o stays high for exactly one cycle. The unit is idle again in that cycle.
- R9: A start_i pulse that arrives while an operation is in progress is ignored. It does not alter that operation's result or timing, and it produces no extra done pulse.
- R10: After synchronous active-low reset, ax_o, dx_o, cf_o, of_o, div_err_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request an operation; sampled only when idle |
| op_div_i | input | 1 | 0 selects multiply, 1 selects divide |
| word_i | input | 1 | 0 selects byte width, 1 selects word width |
| src_i | input | 16 | Source operand (low byte used for byte width) |
| ax_i | input | 16 | Current accumulator AX |
| dx_i | input | 16 | Current data register DX |
| ax_o | output | 16 | Updated AX, valid from done_o onward |
| dx_o | output | 16 | Updated DX, valid from done_o onward |
| cf_o | output | 1 | Carry flag after a multiply |
| of_o | output | 1 | Overflow flag after a multiply |
| div_err_o | output | 1 | Divide error for the last operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted only that the operation, width and operand inputs are known in the cycle where an idle unit samples start_i. Everything is captured there, so the inputs may change freely during an operation.

The bench drives every input from its own tasks on the falling edge and never leaves them unknown. It deliberately scrambles the operands and re-pulses start_i in the middle of an operation, to show the captured values are what count.

Random divides are shaped so that zero divisors, overflowing quotients and valid quotients all appear. This keeps the remainder-bound property exercised on the valid path.

// File: rtl/mdu_pkg.sv
// Package: shared types for the accumulator multiply/divide unit.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package mdu_pkg;

    // Sequencer states: idle, iterating, write-back.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mdu_state_e;

    // Operation captured at start.
    typedef struct packed {
        logic is_div;
        logic wide;
    } mdu_mode_t;

endpackage

// File: rtl/mdu_ctrl.sv
// Module: mdu_ctrl
// Sequences one operation: a load cycle, N iteration cycles (N = DW for
// word width, DW/2 for byte width) and one write-back cycle.
// Assumes: start_i is only honoured in the idle state; any request while
// busy is dropped.
module mdu_ctrl #(
    parameter int DW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic wide_i,
    output logic load_o,
    output logic step_o,
    output logic fin_o
);
    import mdu_pkg::*;

    localparam int HW = DW / 2;
    localparam int CW = $clog2(DW);

    mdu_state_e        state_q;
    logic [CW-1:0]     cnt_q;

    // Decode strobes from the current state.
    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        step_o = (state_q == ST_RUN);
        fin_o  = (state_q == ST_FIN);
    end

    // State and iteration counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= wide_i ? CW'(DW - 1) : CW'(HW - 1);
                    end
                end
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_FIN;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: a busy unit keeps iterating whatever start_i does.
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q != '0) |=> (state_q == ST_RUN));

    // R8: write-back lasts exactly one cycle and returns to idle.
    p_fin_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/mdu_datapath.sv
// Module: mdu_datapath
// Holds the operands and forms the result. Multiply uses right-shift
// shift-and-add. Divide uses left-shift restoring subtraction. Each
// step_i processes one bit. Byte operands are zero-extended into the
// word-width registers, so a single datapath serves both widths.
// Assumes: load_i and step_i are never high together.
module mdu_datapath #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic            is_div_i,
    input  logic            wide_i,
    input  logic [DW-1:0]   src_i,
    input  logic [DW-1:0]   ax_i,
    input  logic [DW-1:0]   dx_i,
    output mdu_pkg::mdu_mode_t mode_o,
    output logic            err_o,
    output logic [DW-1:0]   res_ax_o,
    output logic [DW-1:0]   res_dx_o,
    output logic            hi_nz_o,
    output logic [DW-1:0]   ax_cap_o,
    output logic [DW-1:0]   dx_cap_o
);
    import mdu_pkg::*;

    localparam int HW = DW / 2;

    mdu_mode_t       mode_q;
    logic [DW:0]     upr_q;
    logic [DW-1:0]   lwr_q;
    logic [DW-1:0]   opd_q;
    logic [DW-1:0]   ax_q;
    logic [DW-1:0]   dx_q;
    logic            err_q;

    logic [DW:0]     sum;
    logic [DW:0]     trial;
    logic            fits;
    logic [DW:0]     upr_n;
    logic [DW-1:0]   lwr_n;

    // One iteration of multiply or divide.
    always_comb begin
        sum   = upr_q + (lwr_q[0] ? {1'b0, opd_q} : '0);
        trial = {upr_q[DW-1:0], lwr_q[DW-1]};
        fits  = (trial >= {1'b0, opd_q});
        if (mode_q.is_div) begin
            upr_n = fits ? (trial - {1'b0, opd_q}) : trial;
            lwr_n = {lwr_q[DW-2:0], fits};
        end else begin
            upr_n = {1'b0, sum[DW:1]};
            lwr_n = {sum[0], lwr_q[DW-1:1]};
        end
    end

    // Operand capture at start and per-bit iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            upr_q  <= '0;
            lwr_q  <= '0;
            opd_q  <= '0;
            ax_q   <= '0;
            dx_q   <= '0;
            err_q  <= 1'b0;
        end else if (load_i) begin
            mode_q <= '{is_div: is_div_i, wide: wide_i};
            ax_q   <= ax_i;
            dx_q   <= dx_i;
            if (is_div_i && wide_i) begin
                upr_q <= {1'b0, dx_i};
                lwr_q <= ax_i;
                opd_q <= src_i;
                err_q <= (dx_i >= src_i);
            end else if (is_div_i) begin
                upr_q <= {{(HW + 1){1'b0}}, ax_i[DW-1:HW]};
                lwr_q <= {ax_i[HW-1:0], {HW{1'b0}}};
                opd_q <= {{HW{1'b0}}, src_i[HW-1:0]};
                err_q <= (ax_i[DW-1:HW] >= src_i[HW-1:0]);
            end else begin
                upr_q <= '0;
                lwr_q <= wide_i ? ax_i  : {{HW{1'b0}}, ax_i[HW-1:0]};
                opd_q <= wide_i ? src_i : {{HW{1'b0}}, src_i[HW-1:0]};
                err_q <= 1'b0;
            end
        end else if (step_i) begin
            upr_q <= upr_n;
            lwr_q <= lwr_n;
        end
    end

    // Result selection by operation, width and error.
    always_comb begin
        hi_nz_o = mode_q.wide ? (|upr_q[DW-1:0]) : (|upr_q[HW-1:0]);
        if (err_q) begin
            res_ax_o = ax_q;
            res_dx_o = dx_q;
        end else if (mode_q.wide) begin
            res_ax_o = lwr_q;
            res_dx_o = upr_q[DW-1:0];
        end else if (mode_q.is_div) begin
            res_ax_o = {upr_q[HW-1:0], lwr_q[HW-1:0]};
            res_dx_o = dx_q;
        end else begin
            res_ax_o = {upr_q[HW-1:0], lwr_q[DW-1:HW]};
            res_dx_o = dx_q;
        end
    end

    assign mode_o   = mode_q;
    assign err_o    = err_q;
    assign ax_cap_o = ax_q;
    assign dx_cap_o = dx_q;

    // R5: a valid divide keeps its partial remainder below the divisor.
    p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_q.is_div && !err_q) |-> (upr_q < {1'b0, opd_q}));

    // R3: a multiply never flags a divide error.
    p_mul_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !mode_q.is_div) |-> !err_q);

endmodule

// File: rtl/mdu_accum.sv
// Module: mdu_accum (top)
// Unsigned multiply/divide on implied AX/DX registers, one bit per clock.
// Registers the updated AX/DX, flags and divide error at write-back and
// pulses done_o. Assumes inputs are valid whenever start_i is high.
module mdu_accum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        op_div_i,
    input  logic        word_i,
    input  logic [15:0] src_i,
    input  logic [15:0] ax_i,
    input  logic [15:0] dx_i,
    output logic [15:0] ax_o,
    output logic [15:0] dx_o,
    output logic        cf_o,
    output logic        of_o,
    output logic        div_err_o,
    output logic        done_o
);
    import mdu_pkg::*;

    localparam int DW = 16;

    logic            load;
    logic            step;
    logic            fin;
    mdu_mode_t       mode;
    logic            err;
    logic [DW-1:0]   res_ax;
    logic [DW-1:0]   res_dx;
    logic            hi_nz;
    logic [DW-1:0]   ax_cap;
    logic [DW-1:0]   dx_cap;

    mdu_ctrl #(.DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .wide_i  (word_i),
        .load_o  (load),
        .step_o  (step),
        .fin_o   (fin)
    );

    mdu_datapath #(.DW(DW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .is_div_i (op_div_i),
        .wide_i   (word_i),
        .src_i    (src_i),
        .ax_i     (ax_i),
        .dx_i     (dx_i),
        .mode_o   (mode),
        .err_o    (err),
        .res_ax_o (res_ax),
        .res_dx_o (res_dx),
        .hi_nz_o  (hi_nz),
        .ax_cap_o (ax_cap),
        .dx_cap_o (dx_cap)
    );

    // Architectural outputs updated at write-back only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ax_o      <= '0;
            dx_o      <= '0;
            cf_o      <= 1'b0;
            of_o      <= 1'b0;
            div_err_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= fin;
            if (fin) begin
                ax_o      <= res_ax;
                dx_o      <= res_dx;
                div_err_o <= err;
                if (!mode.is_div) begin
                    cf_o <= hi_nz;
                    of_o <= hi_nz;
                end
            end
        end
    end

    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: an erroring divide returns the captured registers untouched.
    p_err_keeps_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_err_o) |-> (ax_o == ax_cap && dx_o == dx_cap));

    // R3: multiply sets carry and overflow identically.
    p_mul_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode.is_div) |-> (cf_o == of_o && !div_err_o));

    // R1: a byte multiply passes DX through.
    p_byte_dx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode.is_div && !mode.wide) |-> (dx_o == dx_cap));

    // R7: a divide leaves the flags where they were.
    p_div_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode.is_div) |-> ($stable(cf_o) && $stable(of_o)));

endmodule

// File: tb/mdu_accum_tb.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a reference model written from the requirements.
module mdu_accum_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_div_i = 1'b0;
    logic        word_i = 1'b0;
    logic [15:0] src_i = '0;
    logic [15:0] ax_i = '0;
    logic [15:0] dx_i = '0;
    logic [15:0] ax_o;
    logic [15:0] dx_o;
    logic        cf_o;
    logic        of_o;
    logic        div_err_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Model state: flags survive divides.
    logic m_cf = 1'b0;
    logic m_of = 1'b0;

    mdu_accum u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_div_i  (op_div_i),
        .word_i    (word_i),
        .src_i     (src_i),
        .ax_i      (ax_i),
        .dx_i      (dx_i),
        .ax_o      (ax_o),
        .dx_o      (dx_o),
        .cf_o      (cf_o),
        .of_o      (of_o),
        .div_err_o (div_err_o),
        .done_o    (done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model from R1..R7.
    task automatic model(input bit dv, input bit wd, input logic [15:0] s,
                         input logic [15:0] a, input logic [15:0] d,
                         output logic [15:0] eax, output logic [15:0] edx,
                         output logic eerr);
        logic [31:0] p;
        logic [31:0] dvd;
        eerr = 1'b0;
        eax  = a;
        edx  = d;
        if (!dv && !wd) begin
            p   = {16'h0, 8'h0, a[7:0]} * {24'h0, s[7:0]};
            eax = p[15:0];
            m_cf = (p[15:8] != 0);
            m_of = m_cf;
        end else if (!dv) begin
            p   = {16'h0, a} * {16'h0, s};
            eax = p[15:0];
            edx = p[31:16];
            m_cf = (p[31:16] != 0);
            m_of = m_cf;
        end else if (!wd) begin
            if (a[15:8] >= s[7:0]) begin
                eerr = 1'b1;
            end else begin
                eax = {8'(a % {8'h0, s[7:0]}), 8'(a / {8'h0, s[7:0]})};
            end
        end else begin
            dvd = {d, a};
            if (d >= s) begin
                eerr = 1'b1;
            end else begin
                eax = 16'(dvd / {16'h0, s});
                edx = 16'(dvd % {16'h0, s});
            end
        end
    endtask

    // Issue one operation, optionally re-pulse start mid-flight, and check.
    task automatic run_op(input bit dv, input bit wd, input logic [15:0] s,
                          input logic [15:0] a, input logic [15:0] d,
                          input bit inject, input string req);
        logic [15:0] eax;
        logic [15:0] edx;
        logic        eerr;
        int          n;
        n = wd ? 16 : 8;
        model(dv, wd, s, a, d, eax, edx, eerr);
        @(negedge clk);
        op_div_i = dv;
        word_i   = wd;
        src_i    = s;
        ax_i     = a;
        dx_i     = d;
        start_i  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= n + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            if (k <= n) begin
                chk(done_o == 1'b0, "R8 early done", 32'(done_o), 32'h0);
            end
            if (inject && k == 2) begin
                // R9: scrambled request while busy
                start_i  = 1'b1;
                op_div_i = ~dv;
                word_i   = ~wd;
                src_i    = ~s;
                ax_i     = ~a;
                dx_i     = ~d;
            end
        end
        chk(done_o == 1'b1, "R8 done timing", 32'(done_o), 32'h1);
        chk(ax_o == eax, req, 32'(ax_o), 32'(eax));
        chk(dx_o == edx, req, 32'(dx_o), 32'(edx));
        chk(div_err_o == eerr, "R6 div_err", 32'(div_err_o), 32'(eerr));
        chk(cf_o == m_cf && of_o == m_of, "R3/R7 flags",
            {30'h0, cf_o, of_o}, {30'h0, m_cf, m_of});
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, inject ? "R9 no extra done" : "R8 pulse width",
            32'(done_o), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk({ax_o, dx_o} == 32'h0, "R10 regs", {ax_o, dx_o}, 32'h0);
        chk({cf_o, of_o, div_err_o, done_o} == 4'h0, "R10 flags",
            32'({cf_o, of_o, div_err_o, done_o}), 32'h0);
        rst_n = 1'b1;

        // R1 example, with upper bytes of AX and src that must be ignored
        run_op(1'b0, 1'b0, 16'hAB05, 16'h12FD, 16'h7777, 1'b0, "R1 byte mul");
        chk(ax_o == 16'h04F1, "R1 FDh*05h", 32'(ax_o), 32'h04F1);
        // R3 byte product with zero upper half clears flags
        run_op(1'b0, 1'b0, 16'h0003, 16'h0005, 16'h1111, 1'b0, "R3 small mul");
        // R2 largest word product, flags set
        run_op(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, "R2 word mul");
        // R7 divide keeps flags set by prior multiply
        run_op(1'b1, 1'b0, 16'h0006, 16'h00C8, 16'h2222, 1'b0, "R4 byte div");
        chk(ax_o == 16'h0221, "R4 C8h/06h", 32'(ax_o), 32'h0221);
        run_op(1'b0, 1'b1, 16'h0100, 16'h00FF, 16'h5555, 1'b0, "R2 word mul small");
        // R5 word divide
        run_op(1'b1, 1'b1, 16'h1234, 16'h5678, 16'h0123, 1'b0, "R5 word div");
        // R6 errors: zero divisor, equal upper half, word overflow
        run_op(1'b1, 1'b0, 16'hFF00, 16'h0010, 16'h3333, 1'b0, "R6 byte div by 0");
        run_op(1'b1, 1'b0, 16'h0005, 16'h0500, 16'h4444, 1'b0, "R6 byte overflow");
        run_op(1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R6 word div by 0");
        run_op(1'b1, 1'b1, 16'h8000, 16'h0001, 16'h8000, 1'b0, "R6 word overflow");
        // R9 requests while busy, both widths
        run_op(1'b0, 1'b1, 16'h1357, 16'h2468, 16'h0000, 1'b1, "R9 busy mul");
        run_op(1'b1, 1'b0, 16'h0007, 16'h0345, 16'h9999, 1'b1, "R9 busy div");

        // Random mix across all operations.
        for (int i = 0; i < 400; i++) begin
            logic [15:0] s;
            logic [15:0] a;
            logic [15:0] d;
            bit dv;
            bit wd;
            dv = $urandom_range(0, 1) == 1;
            wd = $urandom_range(0, 1) == 1;
            s  = 16'($urandom);
            a  = 16'($urandom);
            d  = 16'($urandom);
            if (dv && $urandom_range(0, 7) == 0) s = '0;
            if (dv && s != 0 && $urandom_range(0, 3) != 0) begin
                if (wd) d = d % s;
                else if (s[7:0] != 0) a[15:8] = a[15:8] % s[7:0];
            end
            run_op(dv, wd, s, a, d, $urandom_range(0, 9) == 0,
                   dv ? (wd ? "R5 rand" : "R4 rand") : (wd ? "R2 rand" : "R1 rand"));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule